// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block holds a bank of eight hardware tokens shared by two independent ports, left and right. Software on each side uses a token to claim a shared resource. A port reaches the tokens only while its semaphore select is low and its memory chip enable is high. A 3-bit address picks the token. A write carries a single value on data bit 0: 0 asks for the token and 1 gives it back. A read returns that port's view of the token, copied onto every bit of the 16-bit data bus.

A token has at most one holder. A request for a token the other side holds is parked as pending. The block grants it by itself once the holder releases. When both ports ask for the same free token at the same edge, the left port wins. The interface is synchronous: the block samples the read/write line every clock. A write takes effect at the clock edge where that line is first seen high after being low, which marks the end of the write strobe.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset no token is held and nothing is pending, so both ports read all-ones on all eight addresses.
- R2: Only select low with chip enable high reaches the tokens. When select and chip enable are both low, the access is ignored: no write takes effect, read-valid stays 0 and the read data is all-zeros.
- R3: A write takes effect at the first clock edge where read/write is seen high after being seen low at the previous edge, with access qualified. It uses address bits 2..0 and data bit 0 only. The other data bits have no effect. Holding read/write low does not commit a write.
- R4: A read (qualified access, read/write high, output enable low) sets read-valid to 1 and drives the port's token value onto all 16 data bits in the same cycle. In any other cycle read-valid is 0 and the data is all-zeros.
- R5: A request (data bit 0 = 0) for a free token grants it. From the next cycle the requester reads 0 and the other port reads 1 at that address. The two ports never hold one token at once.
- R6: A request for a token the other port holds stays pending, and the requester keeps reading 1. When the holder releases, the pending port is granted at the same edge and reads 0 from the next cycle.
- R7: A release (data bit 0 = 1) gives up a held token or cancels a pending request. A cancelled request is never granted later.
- R8: When both ports request the same free token at the same edge, the left port is granted. The right request stays pending and is granted when the left port releases.
- R9: An operation on one address leaves the state of every other address unchanged.
- R10: A request by a port that already holds the token leaves it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low (must be high for token access) |
| l_rw | input | 1 | Left read/write: 1 read, 0 write strobe |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left token address |
| l_wdata | input | 16 | Left write data (bit 0 used) |
| l_rdata | output | 16 | Left read data |
| l_rd_vld | output | 1 | Left read data valid |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_rw | input | 1 | Right read/write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right token address |
| r_wdata | input | 16 | Right write data (bit 0 used) |
| r_rdata | output | 16 | Right read data |
| r_rd_vld | output | 1 | Right read data valid |

## Verification
Two ports can commit at the same edge, and they can touch the same token: two requests collide, or one port releases while the other is pending or requesting. The bench lines up both write strobes so that their read/write rising edges fall in one cycle. Where that cycle leads depends on the order of events, so the bench judges the result by reading all eight addresses from both ports afterwards. It checks that the left port won a tie, and that a pending request was granted in the cycle the release committed.

// File: rtl/sem_pkg.sv
// Package: shared widths and the per-port decoded command for the token unit.
// Assumes both ports share one clock domain.
package sem_pkg;
    localparam int SEM_ADDR_W = 3;
    localparam int SEM_DATA_W = 16;
    localparam int SEM_NUM    = 1 << SEM_ADDR_W;

    // One port's decoded activity in the current cycle.
    typedef struct packed {
        logic wr;   // write committing at this edge
        logic val;  // committed value: 0 request, 1 release
        logic rd;   // read being driven this cycle
    } sem_cmd_t;
endpackage

// File: rtl/sem_port_decode.sv
// Module: decodes one port's control pins into a commit strobe and read enable.
// Assumes pins are synchronous to clk; a write commits on a seen 0->1 of rw.
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int DATA_W = SEM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    output sem_cmd_t          cmd
);
    logic rw_q;
    logic acc_ok;

    // Remember last sampled rw to find the end of a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rw_q <= 1'b1;
        else        rw_q <= rw;
    end

    // Qualify access and form the command.
    always_comb begin
        acc_ok  = !sel_n && ce_n;
        cmd.wr  = acc_ok && rw && !rw_q;
        cmd.val = wdata[0];
        cmd.rd  = acc_ok && rw && !oe_n;
    end

    assert_commit_follows_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.wr |-> ($past(rw) == 1'b0));
    assert_illegal_no_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !ce_n) |-> (!cmd.wr && !cmd.rd));
endmodule

// File: rtl/sem_flag_cell.sv
// Module: one token with holder and pending state for both ports.
// Assumes requests/releases are already address-decoded; left wins ties.
module sem_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r
);
    logic pend_l, pend_r;
    logic n_own_l, n_own_r, n_pend_l, n_pend_r;

    // Apply releases and requests, then grant a free token to a pending side.
    always_comb begin
        n_own_l  = own_l;
        n_own_r  = own_r;
        n_pend_l = pend_l;
        n_pend_r = pend_r;
        if (rel_l) begin
            n_own_l  = 1'b0;
            n_pend_l = 1'b0;
        end else if (req_l && !own_l) begin
            n_pend_l = 1'b1;
        end
        if (rel_r) begin
            n_own_r  = 1'b0;
            n_pend_r = 1'b0;
        end else if (req_r && !own_r) begin
            n_pend_r = 1'b1;
        end
        if (!n_own_l && !n_own_r) begin
            if (n_pend_l) begin
                n_own_l  = 1'b1;
                n_pend_l = 1'b0;
            end else if (n_pend_r) begin
                n_own_r  = 1'b1;
                n_pend_r = 1'b0;
            end
        end
    end

    // Token state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_l  <= 1'b0;
            own_r  <= 1'b0;
            pend_l <= 1'b0;
            pend_r <= 1'b0;
        end else begin
            own_l  <= n_own_l;
            own_r  <= n_own_r;
            pend_l <= n_pend_l;
            pend_r <= n_pend_r;
        end
    end

    assert_single_holder_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_l && own_r));
    assert_pending_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_r && rel_r && pend_l) |=> own_l);
    assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_l && !own_r && !pend_l && !pend_r && req_l && req_r && !rel_l && !rel_r)
        |=> (own_l && pend_r));
    assert_holder_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l && !rel_l) |=> own_l);
    assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_l && !own_l) |=> !own_l);
endmodule

// File: rtl/sem_flag_unit.sv
// Module: two-port token unit; eight tokens, request/release by bit 0,
// status returned on all data bits. Assumes one clock for both ports.
module sem_flag_unit
    import sem_pkg::*;
#(
    parameter int ADDR_W = SEM_ADDR_W,
    parameter int DATA_W = SEM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rd_vld,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rd_vld
);
    localparam int NUM = 1 << ADDR_W;

    sem_cmd_t        l_cmd, r_cmd;
    logic [NUM-1:0]  own_l, own_r;

    sem_port_decode #(.DATA_W(DATA_W)) u_dec_l (
        .clk(clk), .rst_n(rst_n), .sel_n(l_sel_n), .ce_n(l_ce_n),
        .rw(l_rw), .oe_n(l_oe_n), .wdata(l_wdata), .cmd(l_cmd)
    );

    sem_port_decode #(.DATA_W(DATA_W)) u_dec_r (
        .clk(clk), .rst_n(rst_n), .sel_n(r_sel_n), .ce_n(r_ce_n),
        .rw(r_rw), .oe_n(r_oe_n), .wdata(r_wdata), .cmd(r_cmd)
    );

    // One cell per token, each fed by its own address match.
    for (genvar i = 0; i < NUM; i++) begin : g_cell
        logic hit_l, hit_r;
        assign hit_l = l_cmd.wr && (l_addr == ADDR_W'(i));
        assign hit_r = r_cmd.wr && (r_addr == ADDR_W'(i));
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(hit_l && !l_cmd.val), .rel_l(hit_l && l_cmd.val),
            .req_r(hit_r && !r_cmd.val), .rel_r(hit_r && r_cmd.val),
            .own_l(own_l[i]), .own_r(own_r[i])
        );
    end

    // Read return: token view (0 = held by this port) copied to every bit.
    always_comb begin
        l_rd_vld = l_cmd.rd;
        r_rd_vld = r_cmd.rd;
        l_rdata  = l_cmd.rd ? {DATA_W{~own_l[l_addr]}} : '0;
        r_rdata  = r_cmd.rd ? {DATA_W{~own_r[r_addr]}} : '0;
    end

    assert_bus_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd_vld |-> (l_rdata == '0 || l_rdata == '1));
    assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n) |-> (!r_rd_vld && r_rdata == '0));
    assert_reset_free_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (own_l == '0 && own_r == '0));
endmodule

// File: tb/sem_flag_unit_tb.sv
// Bench: vector table of paired port writes with expected views, then directed tests.
module sem_flag_unit_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic l_sel_n, l_ce_n, l_rw, l_oe_n, r_sel_n, r_ce_n, r_rw, r_oe_n;
    logic [2:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_rd_vld, r_rd_vld;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    sem_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rd_vld(l_rd_vld),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rd_vld(r_rd_vld)
    );

    // {lcmd[29:28], laddr[27:25], rcmd[24:23], raddr[22:20], expL[19:12], expR[11:4], req[3:0]}
    // cmd: 0 idle, 1 request, 2 release. exp bit i = read value at address i.
    localparam logic [29:0] VEC [12] = '{
        {2'd1,3'd0,2'd0,3'd0,8'hFE,8'hFF,4'd5},  // R5 left takes 0
        {2'd0,3'd0,2'd1,3'd0,8'hFE,8'hFF,4'd6},  // R6 right pends on 0
        {2'd2,3'd0,2'd0,3'd0,8'hFF,8'hFE,4'd6},  // R6 release hands 0 to right
        {2'd1,3'd0,2'd1,3'd3,8'hFF,8'hF6,4'd9},  // R9 left pends 0, right takes 3
        {2'd2,3'd0,2'd0,3'd0,8'hFF,8'hF6,4'd7},  // R7 left cancels pending
        {2'd0,3'd0,2'd2,3'd0,8'hFF,8'hF7,4'd7},  // R7 cancelled not granted
        {2'd1,3'd5,2'd1,3'd5,8'hDF,8'hF7,4'd8},  // R8 tie: left wins 5
        {2'd2,3'd5,2'd0,3'd0,8'hFF,8'hD7,4'd8},  // R8 right gets 5 after release
        {2'd0,3'd0,2'd1,3'd5,8'hFF,8'hD7,4'd10}, // R10 holder re-requests
        {2'd0,3'd0,2'd2,3'd3,8'hFF,8'hDF,4'd9},  // R9 release 3 only
        {2'd1,3'd7,2'd2,3'd5,8'h7F,8'hFF,4'd9},  // R9 mixed addresses
        {2'd2,3'd7,2'd0,3'd0,8'hFF,8'hFF,4'd7}   // R7 all free again
    };

    task automatic idle_all();
        l_sel_n = 1; l_ce_n = 1; l_rw = 1; l_oe_n = 1; l_addr = 0; l_wdata = 0;
        r_sel_n = 1; r_ce_n = 1; r_rw = 1; r_oe_n = 1; r_addr = 0; r_wdata = 0;
    endtask

    task automatic check(input bit ok, input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Paired write: strobe low one cycle, rise next; commit at the following edge.
    task automatic wr(input logic [1:0] lc, input logic [2:0] la,
                      input logic [1:0] rc, input logic [2:0] ra);
        @(negedge clk);
        if (lc != 0) begin
            l_sel_n = 0; l_ce_n = 1; l_rw = 0; l_addr = la;
            l_wdata = (lc == 2) ? 16'h5A5B : 16'hA5A4;
        end
        if (rc != 0) begin
            r_sel_n = 0; r_ce_n = 1; r_rw = 0; r_addr = ra;
            r_wdata = (rc == 2) ? 16'hFFFF : 16'hFFFE;
        end
        @(negedge clk);
        l_rw = 1; r_rw = 1;
        @(negedge clk);
        idle_all();
    endtask

    // Read all eight addresses from both ports and compare with expected views.
    task automatic read_all(input logic [7:0] el, input logic [7:0] er, input int req);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            l_sel_n = 0; l_ce_n = 1; l_rw = 1; l_oe_n = 0; l_addr = 3'(i);
            r_sel_n = 0; r_ce_n = 1; r_rw = 1; r_oe_n = 0; r_addr = 3'(i);
            #2;
            check(l_rd_vld && l_rdata == {16{el[i]}}, req, "left view", l_rdata, {16{el[i]}});
            check(r_rd_vld && r_rdata == {16{er[i]}}, req, "right view", r_rdata, {16{er[i]}});
        end
        @(negedge clk);
        idle_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_all();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset view
        read_all(8'hFF, 8'hFF, 1);

        foreach (VEC[k]) begin
            wr(VEC[k][29:28], VEC[k][27:25], VEC[k][24:23], VEC[k][22:20]);
            read_all(VEC[k][19:12], VEC[k][11:4], int'(VEC[k][3:0]));
        end

        // R2: select and chip enable both low: write ignored, read quiet.
        @(negedge clk);
        l_sel_n = 0; l_ce_n = 0; l_rw = 0; l_addr = 3'd1; l_wdata = 16'h0000;
        @(negedge clk);
        l_rw = 1; l_oe_n = 0;
        #2 check(!l_rd_vld && l_rdata == 16'h0, 2, "illegal read quiet", l_rdata, 16'h0);
        @(negedge clk);
        idle_all();
        read_all(8'hFF, 8'hFF, 2);

        // R3: rw held low with select then select removed before rise: no commit.
        @(negedge clk);
        l_sel_n = 0; l_rw = 0; l_addr = 3'd2; l_wdata = 16'h0000;
        repeat (3) @(negedge clk);
        l_sel_n = 1;
        @(negedge clk);
        l_rw = 1;
        @(negedge clk);
        idle_all();
        read_all(8'hFF, 8'hFF, 3);

        // R3: only bit 0 counts (request with upper bits set, via 16'hFFFE).
        @(negedge clk);
        r_sel_n = 0; r_rw = 0; r_addr = 3'd6; r_wdata = 16'hFFFE;
        @(negedge clk);
        r_rw = 1;
        @(negedge clk);
        idle_all();
        read_all(8'hFF, 8'hBF, 3);

        // R4: output enable high gives no read data.
        @(negedge clk);
        r_sel_n = 0; r_rw = 1; r_oe_n = 1; r_addr = 3'd6;
        #2 check(!r_rd_vld && r_rdata == 16'h0, 4, "oe high quiet", r_rdata, 16'h0);
        @(negedge clk);
        r_oe_n = 0;
        #2 check(r_rd_vld && r_rdata == 16'h0000, 4, "held read zeros", r_rdata, 16'h0000);
        @(negedge clk);
        idle_all();

        // R1: reset while a token is held frees it.
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        read_all(8'hFF, 8'hFF, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule